// File: doc/BRIEF.md
# External SRAM Bus Cycle Sequencer

This block turns single read and write requests from a processor core into bus cycles on an external asynchronous static RAM. It runs on an internal clock at twice the bus rate, so every bus period splits into a low half and a high half. The bus clock output toggles on every internal edge. Each bus cycle occupies exactly one bus period, since only the zero-wait-state case is built. The wait-state count is a package constant fixed at zero.

The core raises `req` for one clock, together with `req_we`, `req_addr` and `req_wdata`. Requests are taken only while the sequencer is idle or in the post-write hold period. An accepted request starts at the next bus-period boundary. A read drives the address, pulls the chip enable low in the high half of the period, and captures the memory's data at the end of the period. A write first spends one full period as a dead zone. In the write period itself the strobe is low in both halves, the data bus is released in the low half, and the data is driven in the high half. The data then stays on the bus for one more period. That hold period is cut short when a read is waiting, so memory and controller never drive the bus together. `done` pulses for one clock when read data is captured or when a write period ends.

Top module: `emc_ctrl`

## Requirements
- R1: While reset is high and on the first sample after it, `mem_bclk` is 0, `mem_ce_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `done` is 0.
- R2: `mem_bclk` changes value on every internal clock edge after reset; a bus period is its low half followed by its high half.
- R3: A request is sampled while idle. If `mem_bclk` is 1 at the sampling edge, its bus period begins at that same edge. If `mem_bclk` is 0, the bus period begins one edge later, and during the extra half the pins stay inactive.
- R4: In a read period `mem_we_n` stays 1 and `mem_ce_n` is 0 only in the high half. `mem_dq_i` is captured at the period's closing edge, and `rd_data` carries it from that edge on.
- R5: Every write period is preceded by one full dead period in which `mem_ce_n` and `mem_we_n` are 1 and `mem_dq_oe` is 0.
- R6: In a write period `mem_we_n` is 0 in both halves. In the low half `mem_dq_oe` is 0 and `mem_ce_n` is 1. In the high half `mem_dq_oe` is 1, `mem_dq_o` equals the request's data and `mem_ce_n` is 0.
- R7: For the full period after a write period, `mem_dq_oe` stays 1 with `mem_dq_o` unchanged, while `mem_ce_n` and `mem_we_n` are 1. Afterwards, with nothing pending, `mem_dq_oe` returns to 0.
- R8: A read accepted in the low half of the hold period releases the data bus (`mem_dq_oe` = 0) for the hold's high half. A write accepted there leaves the data driven until the hold ends.
- R9: `mem_addr` takes the request's address at the edge that starts its period and stays unchanged until the next period starts.
- R10: A request raised during a read, dead or write period is dropped: no further bus cycle follows and memory contents are untouched.
- R11: `done` is high for exactly one clock, on the sample after a read's or a write's closing edge.
- R12: The controller never drives the data bus while a read has the chip enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe from the core |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Last captured read data |
| done | output | 1 | One-clock completion pulse |
| mem_bclk | output | 1 | Bus clock |
| mem_addr | output | AW | External address bus |
| mem_dq_i | input | DW | Data bus as seen from the pads |
| mem_dq_o | output | DW | Data to be driven on the bus |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_o` |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, low for write |

## Verification
Counted from the edge that samples the request, with the bus clock high there, a read shows its chip enable on the second sample. Its data and `done` appear on the third sample. A write runs two dead samples, the strobe-only sample and the driven sample, then `done` on the fifth sample and its hold on the fifth and sixth. With the bus clock low at the sampling edge, every one of these moves one sample later, and the bench checks that extra sample on its own. The bench drives on the falling clock edge and reads the pins one falling edge after each rising edge, so each expected value is tied to a counted sample index. Read data is checked against a bench-side copy of the memory.

// File: rtl/emc_pkg.sv
package emc_pkg;

    // Zero-wait-state operation only: one bus period per bus cycle.
    localparam int unsigned EMC_WAIT   = 0;
    // Internal clock edges per bus period.
    localparam int unsigned EMC_HALVES = 2 * (EMC_WAIT + 1);

    typedef enum logic [2:0] {
        PER_IDLE,
        PER_READ,
        PER_DEAD,
        PER_WRITE,
        PER_HOLD
    } period_e;

    // Periods in which the chip enable may be active.
    function automatic logic is_bus_cycle(input period_e p);
        return (p == PER_READ) || (p == PER_WRITE);
    endfunction

    // Periods in which a new core request may be taken.
    function automatic logic is_accepting(input period_e p);
        return (p == PER_IDLE) || (p == PER_HOLD);
    endfunction

endpackage

// File: rtl/emc_phase.sv
module emc_phase
    import emc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic bclk,
    output logic last_half
);

    localparam int unsigned CW = (EMC_HALVES > 2) ? $clog2(EMC_HALVES) : 1;
    localparam logic [CW-1:0] LAST = CW'(EMC_HALVES - 1);
    localparam logic [CW-1:0] HALF = CW'(EMC_HALVES / 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bclk      = (cnt_q >= HALF);
    assign last_half = (cnt_q == LAST);

    // R2: bus clock toggles on every internal edge
    assert_bclk_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (bclk != $past(bclk)));

    // R2: a period ends in its high half
    assert_end_high_R2: assert property (@(posedge clk) disable iff (rst)
        last_half |-> bclk);

endmodule

// File: rtl/emc_seq.sv
module emc_seq
    import emc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          last_half,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output period_e       per,
    output logic          rd_pend,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata,
    output logic          done
);

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } op_t;

    period_e per_q;
    op_t     pend_q;
    op_t     cur_q;
    op_t     nxt;
    logic    pend_v;
    logic    take;
    logic    nxt_v;
    logic    done_q;

    assign take  = req && is_accepting(per_q) && !pend_v;
    assign nxt_v = pend_v || take;

    always_comb begin
        if (pend_v) begin
            nxt = pend_q;
        end else begin
            nxt.we    = req_we;
            nxt.addr  = req_addr;
            nxt.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q  <= PER_IDLE;
            pend_q <= '0;
            pend_v <= 1'b0;
            cur_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (last_half) begin
                case (per_q)
                    PER_IDLE, PER_HOLD: begin
                        if (nxt_v) begin
                            cur_q  <= nxt;
                            per_q  <= nxt.we ? PER_DEAD : PER_READ;
                            pend_v <= 1'b0;
                        end else begin
                            per_q <= PER_IDLE;
                        end
                    end
                    PER_READ: begin
                        per_q  <= PER_IDLE;
                        done_q <= 1'b1;
                    end
                    PER_DEAD: begin
                        per_q <= PER_WRITE;
                    end
                    PER_WRITE: begin
                        per_q  <= PER_HOLD;
                        done_q <= 1'b1;
                    end
                    default: begin
                        per_q <= PER_IDLE;
                    end
                endcase
            end else if (take) begin
                pend_q <= nxt;
                pend_v <= 1'b1;
            end
        end
    end

    assign per       = per_q;
    assign rd_pend   = pend_v && !pend_q.we;
    assign cur_addr  = cur_q.addr;
    assign cur_wdata = cur_q.wdata;
    assign done      = done_q;

    // R11: completion pulse lasts one clock
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: a request is parked only from an accepting period
    assert_park_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_v) |-> is_accepting($past(per_q)));

    // R5: a write period always follows a dead period
    assert_dead_before_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(per_q == PER_WRITE) |-> ($past(per_q) == PER_DEAD));

endmodule

// File: rtl/emc_pins.sv
module emc_pins
    import emc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  period_e       per,
    input  logic          bclk,
    input  logic          last_half,
    input  logic          rd_pend,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] cur_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] rd_q;

    assign mem_addr  = cur_addr;
    assign mem_ce_n  = !(is_bus_cycle(per) && bclk);
    assign mem_we_n  = (per != PER_WRITE);
    assign mem_dq_o  = cur_wdata;
    assign mem_dq_oe = ((per == PER_WRITE) && bclk) ||
                       ((per == PER_HOLD) && !rd_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if ((per == PER_READ) && last_half) begin
            rd_q <= mem_dq_i;
        end
    end

    assign rd_data = rd_q;

    // R4: chip enable only in the high half of a period
    assert_ce_high_half_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> bclk);

    // R6: write low half leaves the bus released
    assert_wr_first_half_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !bclk) |-> !mem_dq_oe);

    // R6: write high half drives the bus
    assert_wr_second_half_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && bclk) |-> (mem_dq_oe && !mem_ce_n));

    // R7: data is held after the strobe rises
    assert_hold_data_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

    // R9: address moves only when a period begins
    assert_addr_steady_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> (((per == PER_READ) || (per == PER_DEAD)) && !bclk));

    // R12: no drive while a read enables the memory
    assert_no_fight_R12: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && mem_we_n) |-> !mem_dq_oe);

endmodule

// File: rtl/emc_ctrl.sv
module emc_ctrl
    import emc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          mem_bclk,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_dq_i,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    output logic          mem_ce_n,
    output logic          mem_we_n
);

    logic          bclk;
    logic          last_half;
    period_e       per;
    logic          rd_pend;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;

    emc_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .last_half (last_half)
    );

    emc_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .last_half (last_half),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .per       (per),
        .rd_pend   (rd_pend),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .done      (done)
    );

    emc_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .per       (per),
        .bclk      (bclk),
        .last_half (last_half),
        .rd_pend   (rd_pend),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .rd_data   (rd_data)
    );

    assign mem_bclk = bclk;

endmodule

// File: tb/test_emc_ctrl.sv
module test_emc_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          done;
    logic          mem_bclk;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_i;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;
    logic          mem_ce_n;
    logic          mem_we_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    logic [DW-1:0] ram     [16];
    logic [DW-1:0] exp_mem [16];

    always #2 clk = ~clk;

    emc_ctrl #(.AW(AW), .DW(DW)) i_emc_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .done      (done),
        .mem_bclk  (mem_bclk),
        .mem_addr  (mem_addr),
        .mem_dq_i  (mem_dq_i),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 16'h0123 + 16'h0F0F);
    endfunction

    // external memory model
    assign mem_dq_i = (!mem_ce_n && mem_we_n) ? ram[mem_addr[3:0]] : '0;

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) ram[i] <= pat(i);
        end else if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            ram[mem_addr[3:0]] <= mem_dq_o;
        end
    end

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // read: request at this sample; returns on the sample after done
    task automatic rd(input int a, input logic wait_oe, input bit busy);
        logic p0;
        p0 = mem_bclk;
        req = 1'b1; req_we = 1'b0; req_addr = AW'(a);
        step();
        req = 1'b0;
        if (!p0) begin
            chk("R3 wait ce_n", 32'(mem_ce_n), 1);
            chk(wait_oe ? "R8 wait oe" : "R3 wait oe", 32'(mem_dq_oe), 32'(wait_oe));
            step();
        end
        chk("R3 read start bclk", 32'(mem_bclk), 0);
        chk("R4 read low half ce_n", 32'(mem_ce_n), 1);
        chk("R9 read addr", 32'(mem_addr), 32'(a));
        chk("R12 read low half oe", 32'(mem_dq_oe), 0);
        if (busy) begin
            req = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = 16'hDEAD;
        end
        step();
        chk("R4 read high half ce_n", 32'(mem_ce_n), 0);
        chk("R4 read we_n", 32'(mem_we_n), 1);
        chk("R12 read high half oe", 32'(mem_dq_oe), 0);
        chk("R9 read addr held", 32'(mem_addr), 32'(a));
        step();
        req = 1'b0;
        chk("R11 read done", 32'(done), 1);
        chk("R4 read data", 32'(rd_data), 32'(exp_mem[a]));
        chk("R4 read ce_n off", 32'(mem_ce_n), 1);
        step();
        chk("R11 read done drop", 32'(done), 0);
        chk("R9 addr after read", 32'(mem_addr), 32'(a));
    endtask

    // write: request at this sample; returns on the first hold sample
    task automatic wr(input int a, input logic [DW-1:0] d,
                      input logic wait_oe, input logic [DW-1:0] wait_dq);
        logic p0;
        p0 = mem_bclk;
        req = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
        step();
        req = 1'b0;
        if (!p0) begin
            chk("R8 wait oe", 32'(mem_dq_oe), 32'(wait_oe));
            if (wait_oe) chk("R7 wait data", 32'(mem_dq_o), 32'(wait_dq));
            step();
        end
        for (int k = 0; k < 2; k++) begin
            chk("R5 dead ce_n", 32'(mem_ce_n), 1);
            chk("R5 dead we_n", 32'(mem_we_n), 1);
            chk("R5 dead oe", 32'(mem_dq_oe), 0);
            step();
        end
        chk("R6 low half we_n", 32'(mem_we_n), 0);
        chk("R6 low half ce_n", 32'(mem_ce_n), 1);
        chk("R6 low half oe", 32'(mem_dq_oe), 0);
        chk("R9 write addr", 32'(mem_addr), 32'(a));
        step();
        chk("R6 high half we_n", 32'(mem_we_n), 0);
        chk("R6 high half ce_n", 32'(mem_ce_n), 0);
        chk("R6 high half oe", 32'(mem_dq_oe), 1);
        chk("R6 high half data", 32'(mem_dq_o), 32'(d));
        exp_mem[a] = d;
        step();
        chk("R11 write done", 32'(done), 1);
        chk("R7 hold oe", 32'(mem_dq_oe), 1);
        chk("R7 hold data", 32'(mem_dq_o), 32'(d));
        chk("R7 hold ce_n", 32'(mem_ce_n), 1);
        chk("R7 hold we_n", 32'(mem_we_n), 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = pat(i);

        // R1: reset state
        repeat (3) step();
        chk("R1 bclk", 32'(mem_bclk), 0);
        chk("R1 ce_n", 32'(mem_ce_n), 1);
        chk("R1 we_n", 32'(mem_we_n), 1);
        chk("R1 oe", 32'(mem_dq_oe), 0);
        chk("R1 done", 32'(done), 0);
        rst = 1'b0;
        chk("R1 bclk after release", 32'(mem_bclk), 0);

        // R2: bus clock alternates from low
        for (int k = 0; k < 6; k++) begin
            step();
            chk("R2 bclk toggle", 32'(mem_bclk), 32'((k % 2) == 0));
        end

        // R3 R4: read sweep over both request phases
        for (int a = 0; a < 16; a++) begin
            if (a % 2 == 1) step();
            rd(a, 1'b0, 1'b0);
        end

        // write sweep with the four follow-ups out of the hold
        for (int a = 0; a < 16; a++) begin
            logic [DW-1:0] d;
            d = DW'((a * 16'h1111) ^ 16'hA5C3);
            wr(a, d, 1'b0, '0);
            case (a % 4)
                0: begin
                    step();
                    chk("R11 write done drop", 32'(done), 0);
                    chk("R7 hold second half oe", 32'(mem_dq_oe), 1);
                    chk("R7 hold second half data", 32'(mem_dq_o), 32'(d));
                    step();
                    chk("R7 release after hold", 32'(mem_dq_oe), 0);
                end
                1: begin
                    rd(a, 1'b0, 1'b0);
                end
                2: begin
                    step();
                    chk("R7 hold second half oe", 32'(mem_dq_oe), 1);
                    rd(a ^ 8, 1'b0, 1'b0);
                end
                default: begin
                    wr(a ^ 1, DW'(d + 16'h0101), 1'b1, d);
                    step();
                    step();
                end
            endcase
        end

        // read everything back
        for (int a = 0; a < 16; a++) begin
            if (a % 3 == 0) step();
            rd(a, 1'b0, 1'b0);
        end

        // R10: request during a read is dropped
        rd(5, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            chk("R10 no cycle ce_n", 32'(mem_ce_n), 1);
            chk("R10 no cycle we_n", 32'(mem_we_n), 1);
            chk("R10 no cycle oe", 32'(mem_dq_oe), 0);
            step();
        end
        rd(5, 1'b0, 1'b0);
        chk("R10 memory untouched", 32'(rd_data), 32'(exp_mem[5]));

        summary();
        $finish;
    end

endmodule